// File: doc/BRIEF.md
# Event Counter Box with Sticky Overflow and Freeze

This block is a performance monitoring unit for a power-management domain. It has four general event counters and one free-running cycle counter, all 48 bits wide. Each general counter picks one of the event lines from an event bus. Each event line carries one bit per core. A core mask decides which cores' activity counts. A counter moves by at most one per clock, and only while its own enable bit and the global enable input are both high. Pulling the global enable low freezes every counter at once. Raising it again resumes counting from the frozen values.

A counter wraps from all ones to zero. When it does, a sticky status bit for that counter is set, and the status vector drives the overflow output toward the global monitor. If that counter's interrupt-enable bit is set, a one-cycle interrupt pulse is also sent, but only when the status bit goes from clear to set. The status bit stays set until software writes a one to the matching bit of the clear register. While it stays set, later wraps of the same counter raise no new pulse. Software can preload any counter through its data register, so that it overflows after a chosen number of events.

The register port is a plain single-cycle write strobe with an address, plus a combinational read path. It has no back-pressure, because every access completes in the cycle it is presented. The event bus and the global enable are plain level inputs, sampled on every clock.

Address map (5-bit address), where index k is 0 to 3 for the general counters and 4 for the cycle counter:
- Address k is the control register of counter k.
- Address 8+k is the data register of counter k.
- Address 16 is the read-only status register.
- Address 17 is the write-one-to-clear register.

Top module: `pmon_box`

## Requirements
- R1: After reset, every control register, every counter, the status register, the overflow output and the interrupt output read as zero.
- R2: In a general counter's control register, bit 0 is the local enable. A general counter increments by exactly one in a cycle when three things hold: its local enable is set, the global enable is high, and its selected event line is high for at least one core whose mask bit is set. It never increments by more than one per cycle.
- R3: Control bits 4:2 select the event number e (0 to 7). Event e for core c is input bit e*8+c of the event bus. Activity on any other event number has no effect on that counter.
- R4: Control bits 15:8 form a one-hot-per-core mask, where bit 8+c enables core c. An event asserted only on cores whose mask bit is clear leaves the counter unchanged.
- R5: The cycle counter (control address 4, data address 12) increments by one on every clock while its control bit 0 and the global enable are both high, whatever the event bus does.
- R6: While the global enable is low, no counter changes except by a data write. Counting resumes from the held value once the global enable returns high.
- R7: A counter that increments from all ones wraps to zero and sets its status bit. Bits 3:0 of the status register are the general counters and bit 4 is the cycle counter. The overflow output equals the status register.
- R8: A status bit stays set until a write of one to the matching bit of address 17. That clear takes effect on the same clock edge. A wrap in the same cycle as the clear leaves the bit set.
- R9: Control bit 1 is the interrupt enable. The interrupt output is high for one cycle, in the cycle after the edge on which a status bit with its interrupt enable set goes from clear to set. A wrap that finds the bit already set, or whose interrupt enable is clear, raises no pulse.
- R10: A write to a data register loads the low 48 bits on the next edge. It takes priority over an increment in the same cycle, and that cycle produces no wrap.
- R11: A counter with control bit 0 clear holds its value regardless of events and the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address for both read and write |
| reg_wdata_i | input | 48 | Write data |
| reg_rdata_o | output | 48 | Combinational read data for reg_addr_i |
| evt_i | input | 64 | Event bus, bit e*8+c is event e on core c |
| glob_en_i | input | 1 | Global enable; low freezes all counting |
| ovf_o | output | 5 | Sticky overflow status toward the global monitor |
| irq_o | output | 1 | One-cycle interrupt request toward the global monitor |

## Verification
The hold and single-step properties assume that a data write is the only way, other than a gated increment, to change a counter. The stickiness property assumes that status bits clear only through the clear register. Accordingly, the stimulus reaches the counters only through the register port, the event bus and the global enable. The stimulus combines directed sequences with a random phase. The directed sequences place a preload, a wrap and a clear on chosen edges, including a wrap and a clear on the same edge. The random phase toggles events, masks and the global enable while counters sit near all ones, so that wraps land with and without interrupt enables and with and without a pending status bit.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_IRQ_BIT  = 1;
  localparam int CTL_SEL_LSB  = 2;
  localparam int CTL_MASK_LSB = 8;
  localparam int ADDR_W       = 5;
  localparam logic [ADDR_W-1:0] DATA_BASE = 5'd8;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 5'd16;
  localparam logic [ADDR_W-1:0] CLR_ADDR  = 5'd17;
endpackage

// File: rtl/pmon_evt_filter.sv
module pmon_evt_filter #(
  parameter int N_EVT   = 8,
  parameter int N_CORES = 8,
  localparam int SEL_W  = $clog2(N_EVT)
) (
  input  logic [N_EVT*N_CORES-1:0] evt_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [N_CORES-1:0]       mask_i,
  output logic                     hit_o
);
  logic [N_CORES-1:0] lanes [N_EVT];

  for (genvar e = 0; e < N_EVT; e++) begin : g_lane
    assign lanes[e] = evt_i[e*N_CORES +: N_CORES];
  end

  assign hit_o = |(lanes[sel_i] & mask_i);
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = inc_i & ~wr_i & (cnt_q == ALL_ONES);
  assign cnt_o  = cnt_q;

  // R2: without a write the counter moves by zero or one
  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  // R7: a wrap lands on zero
  p_wrap_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));

  // R10: a write wins over an increment
  p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/pmon_ovf_status.sv
module pmon_ovf_status #(
  parameter int N_CTR = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CTR-1:0] wrap_i,
  input  logic [N_CTR-1:0] clr_i,
  input  logic [N_CTR-1:0] irq_en_i,
  output logic [N_CTR-1:0] stat_o,
  output logic             irq_o
);
  logic [N_CTR-1:0] stat_q;
  logic             irq_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | wrap_i;
      irq_q  <= |(wrap_i & ~stat_q & irq_en_i);
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  // R8: with no clear, no status bit drops
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R8: a wrap in the same cycle as its clear keeps the bit
  p_wrap_beats_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(wrap_i & clr_i)) |=> (|(stat_q & $past(wrap_i & clr_i))));

  // R9: a pulse only follows a fresh rise of an enabled bit
  p_irq_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (|(stat_q & ~$past(stat_q) & $past(irq_en_i))));
endmodule

// File: rtl/pmon_box.sv
module pmon_box
  import pmon_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int N_GEN   = 4,
  parameter int N_EVT   = 8,
  parameter int N_CORES = 8,
  localparam int N_CTR  = N_GEN + 1,
  localparam int SEL_W  = $clog2(N_EVT),
  localparam int EVT_W  = N_EVT * N_CORES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              glob_en_i,
  output logic [N_CTR-1:0]  ovf_o,
  output logic              irq_o
);
  logic [N_CTR-1:0]   ctl_en, ctl_irq, ctl_wr, data_wr, hit, inc, wrap;
  logic [N_CTR-1:0]   clr_vec;
  logic [SEL_W-1:0]   ctl_sel  [N_GEN];
  logic [N_CORES-1:0] ctl_mask [N_GEN];
  logic [CNT_W-1:0]   cnt      [N_CTR];
  logic [CNT_W-1:0]   ctl_rd   [N_CTR];

  assign clr_vec = (reg_we_i && reg_addr_i == CLR_ADDR) ? reg_wdata_i[N_CTR-1:0] : '0;

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    assign ctl_wr[i]  = reg_we_i && (reg_addr_i == ADDR_W'(i));
    assign data_wr[i] = reg_we_i && (reg_addr_i == DATA_BASE + ADDR_W'(i));

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        ctl_en[i]  <= 1'b0;
        ctl_irq[i] <= 1'b0;
      end else if (ctl_wr[i]) begin
        ctl_en[i]  <= reg_wdata_i[CTL_EN_BIT];
        ctl_irq[i] <= reg_wdata_i[CTL_IRQ_BIT];
      end
    end

    if (i < N_GEN) begin : g_gen
      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          ctl_sel[i]  <= '0;
          ctl_mask[i] <= '0;
        end else if (ctl_wr[i]) begin
          ctl_sel[i]  <= reg_wdata_i[CTL_SEL_LSB +: SEL_W];
          ctl_mask[i] <= reg_wdata_i[CTL_MASK_LSB +: N_CORES];
        end
      end

      pmon_evt_filter #(.N_EVT(N_EVT), .N_CORES(N_CORES)) u_filt (
        .evt_i  (evt_i),
        .sel_i  (ctl_sel[i]),
        .mask_i (ctl_mask[i]),
        .hit_o  (hit[i])
      );

      always_comb begin
        ctl_rd[i] = '0;
        ctl_rd[i][CTL_EN_BIT]  = ctl_en[i];
        ctl_rd[i][CTL_IRQ_BIT] = ctl_irq[i];
        ctl_rd[i][CTL_SEL_LSB +: SEL_W]    = ctl_sel[i];
        ctl_rd[i][CTL_MASK_LSB +: N_CORES] = ctl_mask[i];
      end

      // R4: an empty mask never lets the counter move on its own
      p_empty_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!data_wr[i] && ctl_mask[i] == '0) |=> $stable(cnt[i]));
    end else begin : g_fix
      assign hit[i] = 1'b1;

      always_comb begin
        ctl_rd[i] = '0;
        ctl_rd[i][CTL_EN_BIT]  = ctl_en[i];
        ctl_rd[i][CTL_IRQ_BIT] = ctl_irq[i];
      end
    end

    assign inc[i] = ctl_en[i] & glob_en_i & hit[i];

    pmon_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[i]),
      .wr_i    (data_wr[i]),
      .wdata_i (reg_wdata_i),
      .cnt_o   (cnt[i]),
      .wrap_o  (wrap[i])
    );

    // R6: a frozen box holds every counter
    p_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!glob_en_i && !data_wr[i]) |=> $stable(cnt[i]));

    // R11: a locally disabled counter holds
    p_local_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctl_en[i] && !data_wr[i]) |=> $stable(cnt[i]));
  end

  pmon_ovf_status #(.N_CTR(N_CTR)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .clr_i    (clr_vec),
    .irq_en_i (ctl_irq),
    .stat_o   (ovf_o),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < N_CTR; k++) begin
      if (reg_addr_i == ADDR_W'(k))             reg_rdata_o = ctl_rd[k];
      if (reg_addr_i == DATA_BASE + ADDR_W'(k)) reg_rdata_o = cnt[k];
    end
    if (reg_addr_i == STAT_ADDR) reg_rdata_o = CNT_W'(ovf_o);
  end

  // R1: outputs are quiet in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (ovf_o == '0 && !irq_o));
endmodule

// File: tb/pmon_box_tb.sv
`timescale 1ns/1ps
module pmon_box_tb_top;
  localparam logic [47:0] MAX = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [47:0] wdata = '0;
  logic [47:0] rdata;
  logic [63:0] evt = '0;
  logic        gen = 1'b0;
  logic [4:0]  ovf;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pmon_box dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt),
    .glob_en_i(gen), .ovf_o(ovf), .irq_o(irq)
  );

  // behavioural reference state
  logic [47:0] m_cnt [5];
  logic [4:0]  m_en, m_irqen, m_stat;
  logic [2:0]  m_sel [4];
  logic [7:0]  m_mask [4];
  logic        m_irq;

  always @(posedge clk) begin
    logic [4:0] ov;
    logic [4:0] clr;
    logic hit, inc, wr;
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_cnt[i] = '0;
      for (int i = 0; i < 4; i++) begin m_sel[i] = '0; m_mask[i] = '0; end
      m_en = '0; m_irqen = '0; m_stat = '0; m_irq = 1'b0;
    end else begin
      ov  = '0;
      clr = (we && addr == 5'd17) ? wdata[4:0] : 5'd0;
      for (int i = 0; i < 5; i++) begin
        hit = (i == 4) ? 1'b1 : |(evt[m_sel[i]*8 +: 8] & m_mask[i]);
        inc = m_en[i] && gen && hit;
        wr  = we && (addr == 5'(8 + i));
        if (wr) m_cnt[i] = wdata;
        else if (inc) begin
          if (m_cnt[i] == MAX) begin ov[i] = 1'b1; m_cnt[i] = '0; end
          else m_cnt[i] = m_cnt[i] + 48'd1;
        end
      end
      m_irq  = |(ov & ~m_stat & m_irqen);
      m_stat = (m_stat & ~clr) | ov;
      if (we && addr < 5'd5) begin
        m_en[addr]    = wdata[0];
        m_irqen[addr] = wdata[1];
        if (addr < 5'd4) begin
          m_sel[addr[1:0]]  = wdata[4:2];
          m_mask[addr[1:0]] = wdata[15:8];
        end
      end
    end
  end

  function automatic logic [47:0] exp_rd(input logic [4:0] a);
    logic [47:0] v = '0;
    if (a < 5'd4) begin
      v[0] = m_en[a]; v[1] = m_irqen[a]; v[4:2] = m_sel[a[1:0]]; v[15:8] = m_mask[a[1:0]];
    end else if (a == 5'd4) begin
      v[0] = m_en[4]; v[1] = m_irqen[4];
    end else if (a >= 5'd8 && a <= 5'd12) v = m_cnt[a - 5'd8];
    else if (a == 5'd16) v = {43'd0, m_stat};
    return v;
  endfunction

  // per-cycle comparison of the monitor outputs, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (ovf !== m_stat) begin
        fails++;
        $display("FAIL R7 ovf_o actual=%b expected=%b at %0t", ovf, m_stat, $time);
      end
      vectors++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL R9 irq_o actual=%b expected=%b at %0t", irq, m_irq, $time);
      end
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [47:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [4:0] a, input string tag);
    logic [47:0] e;
    addr = a;
    #1;
    e = exp_rd(a);
    vectors++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, e);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: everything reads zero
    for (int a = 0; a < 18; a++) rd_chk(5'(a), "R1");

    gen = 1'b1;
    wr_reg(5'd0, 48'h0509);   // en, event 2, cores 0 and 2
    wr_reg(5'd1, 48'hFF15);   // en, event 5, all cores
    evt = 64'd1 << 17; idle(3); evt = '0; rd_chk(5'd8, "R4");
    evt = 64'd1 << 16; idle(2); evt = '0; rd_chk(5'd8, "R2");
    evt = (64'd1 << 16) | (64'd1 << 18); idle(4); evt = '0; rd_chk(5'd8, "R2");
    evt = 64'd1 << 24; idle(3); evt = '0; rd_chk(5'd8, "R3");
    evt = 64'd1 << 43; idle(3); evt = '0; rd_chk(5'd9, "R3");
    rd_chk(5'd0, "R2");

    wr_reg(5'd4, 48'h1); idle(10); rd_chk(5'd12, "R5");
    evt = 64'hFFFF_FFFF_FFFF_FFFF;
    gen = 1'b0; idle(5); rd_chk(5'd12, "R6"); rd_chk(5'd8, "R6"); rd_chk(5'd9, "R6");
    gen = 1'b1; idle(3); rd_chk(5'd12, "R6"); rd_chk(5'd8, "R6");
    evt = '0;

    wr_reg(5'd0, 48'h050B);            // add interrupt enable
    wr_reg(5'd8, MAX - 48'd1);
    evt = 64'd1 << 16; idle(4);
    rd_chk(5'd16, "R7"); rd_chk(5'd8, "R7");
    wr_reg(5'd8, MAX); idle(3);        // second wrap while pending: no pulse
    rd_chk(5'd16, "R9");
    wr_reg(5'd8, MAX); wr_reg(5'd17, 48'h1); idle(1);  // wrap and clear on one edge
    rd_chk(5'd16, "R8");
    wr_reg(5'd17, 48'h1); idle(1); rd_chk(5'd16, "R8");
    wr_reg(5'd8, 48'd100); rd_chk(5'd8, "R10"); idle(2); rd_chk(5'd8, "R10");
    wr_reg(5'd8, MAX); rd_chk(5'd16, "R10");
    idle(2); rd_chk(5'd16, "R9");
    wr_reg(5'd17, 48'h1F);
    wr_reg(5'd0, 48'h050A); idle(3); rd_chk(5'd8, "R11");
    evt = '0;

    wr_reg(5'd0, 48'h0F01); wr_reg(5'd1, 48'h3307);
    wr_reg(5'd2, 48'hC00B); wr_reg(5'd3, 48'hFF1D);
    wr_reg(5'd4, 48'h3);
    for (int i = 0; i < 5; i++) wr_reg(5'(8 + i), MAX - 48'(i * 7 + 15));
    for (int c = 0; c < 400; c++) begin
      evt = {$urandom, $urandom};
      gen = ($urandom % 5) != 0;
      if (($urandom % 37) == 0) wr_reg(5'd17, 48'($urandom % 32));
      else if (($urandom % 53) == 0) wr_reg(5'(8 + $urandom % 5), MAX - 48'($urandom % 8));
      else idle(1);
    end
    evt = '0;
    for (int i = 0; i < 5; i++) rd_chk(5'(8 + i), "R2");
    rd_chk(5'd16, "R8");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule